// File: doc/BRIEF.md
# Dual-Channel DAC Load Controller

This block is the digital front end of a two-channel 12-bit converter. Each channel owns a control word and a data word, both written through a simple register port. The block stores the written code, reshapes it for the selected resolution and number format, and decides on which clock edge the code is copied into the channel's output latch. The output latch drives the converter core, which is not part of this block. The latched code is therefore presented as a plain digital output.

A channel can load its latch in four ways. It can load on every write to its data word. It can load once every channel in its group has been written. It can load on a rising edge of either of two external timer signals. The timer signals may be asynchronous to the system clock. Each load raises a per-channel flag. The flag is masked by an enable bit to form an interrupt request. Software clears the flag, or a hardware acknowledge pulse clears it.

Top module: `dacld_top`

## Requirements
- R1: A data-word write stores wrData[11:0]. Reading the data word back (rdSel=1) returns that value with bits 15..12 as zero. Reading the control word (rdSel=0) returns the layout given in R2 to R11, with bits 15..8 as zero.
- R2: With control bit 2 (res8) clear and control bit 3 (twos) clear, the latched code equals the 12-bit data value unchanged.
- R3: With control bit 3 (twos) set, the data is treated as signed. The latch receives offset binary, which is the data with its top bit inverted at the active width (bit 11 in 12-bit mode, bit 7 in 8-bit mode).
- R4: With control bit 2 (res8) set, data bits 11..8 are ignored. The latch receives the 8-bit code in its bits 11..4, with bits 3..0 zero.
- R5: Load select, control bits 1..0, value 00: the latch takes the newly written value on the same clock edge that writes the data word.
- R6: Load select 01 with control bit 5 (group) set on channel 0: neither latch changes until both channels' data words have been written. A repeated write to one channel before then only replaces its pending value. Both latches load on the edge of the completing write, after which the written tracking starts again from empty.
- R7: The group bit on channel 1, the highest channel, has no effect. With channel 0 ungrouped, a channel in load select 01 loads on its own write.
- R8: Load select 10 loads on a rising edge of timerA, and load select 11 loads on a rising edge of timerB. The latch changes on the third rising clock edge after the timer input rises. A held-high timer input, or a data write, causes no further load.
- R9: No latch load happens while control bit 4 (enable) is clear. Setting the enable bit does not load the latch by itself.
- R10: Every latch load sets the channel's flag, which reads back as control bit 7. irq[i] is high exactly when the flag is set and control bit 6 (interrupt enable) is set.
- R11: A control-word write with bit 7 clear clears the flag. A one-cycle pulse on irqAck[i] also clears it. A control-word write with bit 7 set leaves the flag unchanged.
- R12: After reset, all control words, data words and latched codes are zero, and no irq is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Register write strobe |
| wrChan | input | 1 | Channel addressed by a write |
| wrSel | input | 1 | 0 selects the control word, 1 selects the data word |
| wrData | input | 16 | Write value |
| rdChan | input | 1 | Channel addressed by the read port |
| rdSel | input | 1 | 0 reads the control word, 1 reads the data word |
| rdData | output | 16 | Combinational read value |
| timerA | input | 1 | Asynchronous timer trigger A |
| timerB | input | 1 | Asynchronous timer trigger B |
| irqAck | input | 2 | Per-channel flag clear pulse |
| dacCode | output | 24 | Latched codes, channel 0 in bits 11..0 |
| irq | output | 2 | Per-channel interrupt request |

## Verification
The formatting path is driven with random data under random resolution and format settings in immediate-load mode. This separates straight, signed, 8-bit and 12-bit handling, and catches a missed inversion or a missed mask. Directed sequences cover the other cases:
- signed extremes at both widths;
- group writes that repeat a channel before completion, which separate tracking per channel from a simple write count;
- a held timer level, which separates edge detection from level detection and pins the three-cycle latency;
- a disabled channel, which exposes loads that escape the enable gate.

// File: rtl/dacld_pkg.sv
`timescale 1ns/1ps
package dacld_pkg;

  // Latch update source, value held in control bits 1..0.
  typedef enum logic [1:0] {
    LD_WRITE = 2'b00,
    LD_GROUP = 2'b01,
    LD_TMRA  = 2'b10,
    LD_TMRB  = 2'b11
  } loadSel_e;

  // Control word, bit 7 down to bit 0.
  typedef struct packed {
    logic     flag;
    logic     irqEn;
    logic     grp;
    logic     en;
    logic     twos;
    logic     res8;
    loadSel_e lsel;
  } chanCtl_t;

  // Strobes from control to datapath, one set per channel.
  typedef struct packed {
    logic wrCtl;
    logic wrDat;
    logic load;
  } chanStb_t;

endpackage

// File: rtl/dacld_ctrl.sv
`timescale 1ns/1ps
module dacld_ctrl
  import dacld_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [CW-1:0]        wrChan,
  input  logic                 wrSel,
  input  logic                 timerA,
  input  logic                 timerB,
  input  chanCtl_t [NCH-1:0]   ctl,
  output chanStb_t [NCH-1:0]   stb
);

  localparam int NTMR = 2;

  logic [NTMR-1:0] tmrIn;
  logic [NTMR-1:0] tmrRise;
  assign tmrIn = {timerB, timerA};

  // Synchroniser plus one history flop per timer input
  for (genvar t = 0; t < NTMR; t++) begin : g_tmr
    logic [SYNC_STAGES:0] sh;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) sh <= '0;
      else       sh <= {sh[SYNC_STAGES-1:0], tmrIn[t]};
    end
    assign tmrRise[t] = sh[SYNC_STAGES-1] & ~sh[SYNC_STAGES];
  end

  // A channel's group is the contiguous run joined by link bits.
  function automatic logic [NCH-1:0] groupDone(input logic [NCH-1:0] pend,
                                               input logic [NCH-1:0] link);
    logic [NCH-1:0] fwd;
    logic [NCH-1:0] bwd;
    fwd[0] = pend[0];
    for (int i = 1; i < NCH; i++)
      fwd[i] = pend[i] & (link[i-1] ? fwd[i-1] : 1'b1);
    bwd[NCH-1] = pend[NCH-1];
    for (int i = NCH - 2; i >= 0; i--)
      bwd[i] = pend[i] & (link[i] ? bwd[i+1] : 1'b1);
    return fwd & bwd;
  endfunction

  logic [NCH-1:0] dataWr, ctlWr, effGrp, pend, segDone, loadVec;
  logic [NCH-1:0] wrtQ;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      dataWr[i] = wrEn &&  wrSel && (wrChan == CW'(i));
      ctlWr[i]  = wrEn && !wrSel && (wrChan == CW'(i));
      effGrp[i] = (i < NCH - 1) ? ctl[i].grp : 1'b0;
    end
  end

  assign pend    = wrtQ | dataWr;
  assign segDone = groupDone(pend, effGrp);

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      unique case (ctl[i].lsel)
        LD_WRITE: loadVec[i] = dataWr[i];
        LD_GROUP: loadVec[i] = segDone[i];
        LD_TMRA:  loadVec[i] = tmrRise[0];
        LD_TMRB:  loadVec[i] = tmrRise[1];
        default:  loadVec[i] = 1'b0;
      endcase
      loadVec[i] = loadVec[i] & ctl[i].en;
    end
  end

  // Written tracking, cleared whenever the channel's group completes
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrtQ <= '0;
    else       wrtQ <= pend & ~segDone;
  end

  for (genvar i = 0; i < NCH; i++) begin : g_stb
    assign stb[i].wrCtl = ctlWr[i];
    assign stb[i].wrDat = dataWr[i];
    assign stb[i].load  = loadVec[i];
  end

endmodule

// File: rtl/dacld_datapath.sv
`timescale 1ns/1ps
module dacld_datapath
  import dacld_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DW    = 12,
  parameter int LOW_W = 8,
  parameter int REG_W = 16,
  localparam int CW    = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CTL_W = $bits(chanCtl_t),
  localparam int PAD_W = DW - LOW_W
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [REG_W-1:0]     wrData,
  input  logic [NCH-1:0]       irqAck,
  input  chanStb_t [NCH-1:0]   stb,
  input  logic [CW-1:0]        rdChan,
  input  logic                 rdSel,
  output logic [REG_W-1:0]     rdData,
  output chanCtl_t [NCH-1:0]   ctl,
  output logic [NCH*DW-1:0]    dacCode,
  output logic [NCH-1:0]       irq
);

  function automatic logic [DW-1:0] fmtCode(input logic [DW-1:0] d,
                                            input logic res8,
                                            input logic twos);
    logic [DW-1:0] r;
    if (res8) begin
      r = {d[LOW_W-1:0], {PAD_W{1'b0}}};
      r[DW-1] = r[DW-1] ^ twos;
    end else begin
      r = d;
      r[DW-1] = r[DW-1] ^ twos;
    end
    return r;
  endfunction

  logic [NCH-1:0][DW-1:0] datArr;
  chanCtl_t ctlNew;
  assign ctlNew = chanCtl_t'(wrData[CTL_W-1:0]);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    chanCtl_t      ctlQ;
    logic [DW-1:0] datQ;
    logic [DW-1:0] codeQ;
    logic [DW-1:0] srcVal;

    assign srcVal = stb[i].wrDat ? wrData[DW-1:0] : datQ;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        ctlQ  <= '0;
        datQ  <= '0;
        codeQ <= '0;
      end else begin
        if (stb[i].wrCtl) begin
          ctlQ.lsel  <= ctlNew.lsel;
          ctlQ.res8  <= ctlNew.res8;
          ctlQ.twos  <= ctlNew.twos;
          ctlQ.en    <= ctlNew.en;
          ctlQ.grp   <= ctlNew.grp;
          ctlQ.irqEn <= ctlNew.irqEn;
        end
        if (stb[i].load)
          ctlQ.flag <= 1'b1;
        else if (irqAck[i] || (stb[i].wrCtl && !ctlNew.flag))
          ctlQ.flag <= 1'b0;
        if (stb[i].wrDat) datQ <= wrData[DW-1:0];
        if (stb[i].load)  codeQ <= fmtCode(srcVal, ctlQ.res8, ctlQ.twos);
      end
    end

    assign ctl[i]                = ctlQ;
    assign datArr[i]             = datQ;
    assign dacCode[i*DW +: DW]   = codeQ;
    assign irq[i]                = ctlQ.flag & ctlQ.irqEn;
  end

  always_comb begin
    rdData = '0;
    if (rdSel) rdData[DW-1:0]    = datArr[rdChan];
    else       rdData[CTL_W-1:0] = ctl[rdChan];
  end

endmodule

// File: rtl/dacld_top.sv
`timescale 1ns/1ps
module dacld_top
  import dacld_pkg::*;
#(
  parameter int NCH         = 2,
  parameter int DW          = 12,
  parameter int LOW_W       = 8,
  parameter int REG_W       = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CW         = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [CW-1:0]     wrChan,
  input  logic              wrSel,
  input  logic [REG_W-1:0]  wrData,
  input  logic [CW-1:0]     rdChan,
  input  logic              rdSel,
  output logic [REG_W-1:0]  rdData,
  input  logic              timerA,
  input  logic              timerB,
  input  logic [NCH-1:0]    irqAck,
  output logic [NCH*DW-1:0] dacCode,
  output logic [NCH-1:0]    irq
);

  chanStb_t [NCH-1:0] stb;
  chanCtl_t [NCH-1:0] ctl;

  dacld_ctrl #(.NCH(NCH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrSel(wrSel),
    .timerA(timerA), .timerB(timerB), .ctl(ctl), .stb(stb)
  );

  dacld_datapath #(.NCH(NCH), .DW(DW), .LOW_W(LOW_W), .REG_W(REG_W)) u_dp (
    .clk(clk), .rstN(rstN), .wrData(wrData), .irqAck(irqAck), .stb(stb),
    .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData), .ctl(ctl),
    .dacCode(dacCode), .irq(irq)
  );

endmodule

// File: rtl/dacld_checker.sv
`timescale 1ns/1ps
module dacld_checker
  import dacld_pkg::*;
#(
  parameter int NCH   = 2,
  parameter int DW    = 12,
  parameter int REG_W = 16
) (
  input logic               clk,
  input logic               rstN,
  input chanStb_t [NCH-1:0] stb,
  input chanCtl_t [NCH-1:0] ctl,
  input logic [NCH*DW-1:0]  dacCode,
  input logic               rdSel,
  input logic [REG_W-1:0]   rdData
);

  // R1: data readback never shows bits above the data width
  a_r1_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    rdSel |-> (rdData[REG_W-1:DW] == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    // R5: a latch only moves on a load strobe
    a_r5_code_holds: assert property (@(posedge clk) disable iff (!rstN)
      !stb[i].load |=> $stable(dacCode[i*DW +: DW]));
    // R9: no load while disabled
    a_r9_load_needs_en: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].load |-> ctl[i].en);
    // R10: a load leaves the flag set
    a_r10_flag_after_load: assert property (@(posedge clk) disable iff (!rstN)
      stb[i].load |=> ctl[i].flag);
  end

  if (NCH > 1) begin : g_grp
    // R6: grouped, enabled channels load together
    a_r6_group_together: assert property (@(posedge clk) disable iff (!rstN)
      (ctl[0].grp && ctl[0].lsel == LD_GROUP && ctl[1].lsel == LD_GROUP &&
       ctl[0].en && ctl[1].en) |-> (stb[0].load == stb[1].load));
  end

endmodule

bind dacld_top dacld_checker #(.NCH(NCH), .DW(DW), .REG_W(REG_W)) u_chk (
  .clk(clk), .rstN(rstN), .stb(stb), .ctl(ctl), .dacCode(dacCode),
  .rdSel(rdSel), .rdData(rdData)
);

// File: tb/dacld_top_test.sv
`timescale 1ns/1ps
module dacld_top_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0, wrChan = 1'b0, wrSel = 1'b0;
  logic [15:0] wrData = '0;
  logic        rdChan = 1'b0, rdSel = 1'b0;
  logic [15:0] rdData;
  logic        timerA = 1'b0, timerB = 1'b0;
  logic [1:0]  irqAck = '0;
  logic [23:0] dacCode;
  logic [1:0]  irq;

  int nChecks = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dacld_top uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrChan(wrChan), .wrSel(wrSel),
    .wrData(wrData), .rdChan(rdChan), .rdSel(rdSel), .rdData(rdData),
    .timerA(timerA), .timerB(timerB), .irqAck(irqAck),
    .dacCode(dacCode), .irq(irq)
  );

  function automatic logic [11:0] fmt(input logic [11:0] d, input bit res8, input bit twos);
    if (res8) return {d[7] ^ twos, d[6:0], 4'b0000};
    return {d[11] ^ twos, d[10:0]};
  endfunction

  // control word: lsel[1:0], res8 b2, twos b3, en b4, grp b5, ie b6, flag b7
  function automatic logic [15:0] cw(input logic [1:0] lsel, input bit res8, input bit twos,
                                     input bit en, input bit grp, input bit ie, input bit keep);
    return {8'h00, keep, ie, grp, en, twos, res8, lsel};
  endfunction

  function automatic logic [11:0] code(input int ch);
    return (ch == 0) ? dacCode[11:0] : dacCode[23:12];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input bit sel, input logic [15:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrChan = ch[0]; wrSel = sel; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int ch, input bit sel, output logic [15:0] v);
    rdChan = ch[0]; rdSel = sel;
    #1 v = rdData;
  endtask

  task automatic ack(input int ch);
    @(negedge clk);
    irqAck[ch] = 1'b1;
    @(negedge clk);
    irqAck = '0;
  endtask

  task automatic finish;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      nChecks++; nFail++;
      $display("FAIL watchdog: actual hung expected done");
      finish();
    end
  end

  initial begin
    logic [15:0] v;
    logic [11:0] c0, c1;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R12 reset state
    chk("R12 code0", code(0), 0);
    chk("R12 code1", code(1), 0);
    chk("R12 irq", irq, 0);
    rd(0, 0, v); chk("R12 ctl0", v, 0);

    // R1 readback, R9 no load when disabled
    wr(0, 0, cw(2'b00, 0, 0, 0, 0, 0, 0));
    wr(0, 1, 16'hFABC);
    rd(0, 1, v); chk("R1 data readback", v, 16'h0ABC);
    chk("R9 disabled no load", code(0), 0);
    rd(0, 0, v); chk("R9 no flag when disabled", v[7], 0);
    wr(0, 0, cw(2'b00, 0, 0, 1, 0, 0, 0));
    chk("R9 enable alone no load", code(0), 0);

    // R5 / R2 immediate load, R10 flag without irq enable
    wr(0, 1, 16'h0123);
    chk("R5 immediate load", code(0), 12'h123);
    chk("R10 irq masked", irq[0], 0);
    rd(0, 0, v); chk("R10 ctl readback with flag", v, 16'h0090);

    // R3 / R4 directed extremes
    wr(1, 0, cw(2'b00, 0, 1, 1, 0, 1, 0));
    wr(1, 1, 16'h0800); chk("R3 12b min", code(1), 12'h000);
    wr(1, 1, 16'h07FF); chk("R3 12b max", code(1), 12'hFFF);
    wr(1, 0, cw(2'b00, 1, 0, 1, 0, 1, 0));
    wr(1, 1, 16'h0F80); chk("R4 8b straight", code(1), 12'h800);
    wr(1, 0, cw(2'b00, 1, 1, 1, 0, 1, 0));
    wr(1, 1, 16'h0A80); chk("R4 R3 8b signed", code(1), 12'h000);

    // random formatting in immediate mode
    for (int n = 0; n < 40; n++) begin
      int ch;
      bit r8, tc;
      logic [15:0] d;
      logic [11:0] other;
      ch = $urandom % 2; r8 = $urandom % 2; tc = $urandom % 2; d = 16'($urandom);
      other = code(1 - ch);
      wr(ch, 0, cw(2'b00, r8, tc, 1, 0, 1, 0));
      chk("R11 ctl write clears flag", irq[ch], 0);
      wr(ch, 1, d);
      chk(r8 ? "R4 random 8b" : (tc ? "R3 random 12b" : "R2 random 12b"),
          code(ch), fmt(d[11:0], r8, tc));
      chk("R5 other channel held", code(1 - ch), other);
      chk("R10 irq raised", irq[ch], 1);
      ack(ch);
      chk("R11 ack clears", irq[ch], 0);
    end

    // R11 keep bit
    wr(0, 0, cw(2'b00, 0, 0, 1, 0, 1, 0));
    wr(0, 1, 16'h0055);
    wr(0, 0, cw(2'b00, 0, 0, 1, 0, 1, 1));
    chk("R11 keep bit holds flag", irq[0], 1);
    wr(0, 0, cw(2'b00, 0, 0, 1, 0, 1, 0));
    chk("R11 write zero clears", irq[0], 0);

    // R6 group mode
    wr(0, 0, cw(2'b01, 0, 0, 1, 1, 1, 0));
    wr(1, 0, cw(2'b01, 0, 0, 1, 0, 1, 0));
    c0 = code(0); c1 = code(1);
    wr(0, 1, 16'h0AAA);
    chk("R6 partial code0", code(0), c0);
    chk("R6 partial code1", code(1), c1);
    wr(0, 1, 16'h0BBB);
    chk("R6 rewrite no load", code(0), c0);
    wr(1, 1, 16'h0CCC);
    chk("R6 group code0", code(0), 12'hBBB);
    chk("R6 group code1", code(1), 12'hCCC);
    chk("R6 R10 both flags", irq, 2'b11);
    wr(1, 1, 16'h0DDD);
    chk("R6 tracking cleared", code(1), 12'hCCC);
    wr(0, 1, 16'h0EEE);
    chk("R6 second group code0", code(0), 12'hEEE);
    chk("R6 second group code1", code(1), 12'hDDD);

    // R7 group bit on last channel
    wr(0, 0, cw(2'b01, 0, 0, 1, 0, 1, 0));
    wr(1, 0, cw(2'b01, 0, 0, 1, 1, 1, 0));
    wr(1, 1, 16'h0123);
    chk("R7 last group bit inert", code(1), 12'h123);
    wr(0, 1, 16'h0321);
    chk("R7 ungrouped ch0 loads", code(0), 12'h321);

    // R8 timers
    wr(0, 0, cw(2'b10, 0, 0, 1, 0, 1, 0));
    wr(1, 0, cw(2'b11, 0, 0, 1, 0, 1, 0));
    wr(0, 1, 16'h0111);
    wr(1, 1, 16'h0222);
    chk("R8 write no load ch0", code(0), 12'h321);
    chk("R8 write no load ch1", code(1), 12'h123);
    @(negedge clk); timerA = 1'b1;
    repeat (2) @(negedge clk);
    chk("R8 latency not early", code(0), 12'h321);
    @(negedge clk);
    chk("R8 timerA load", code(0), 12'h111);
    chk("R8 timerA ignores ch1", code(1), 12'h123);
    wr(0, 1, 16'h0333);
    repeat (4) @(negedge clk);
    chk("R8 held level no reload", code(0), 12'h111);
    timerA = 1'b0; timerB = 1'b1;
    repeat (3) @(negedge clk);
    chk("R8 timerB load", code(1), 12'h222);
    chk("R8 timerB ignores ch0", code(0), 12'h111);
    timerB = 1'b0;

    // R9 disabled timer channel
    wr(0, 0, cw(2'b10, 0, 0, 0, 0, 1, 0));
    @(negedge clk); timerA = 1'b1;
    repeat (4) @(negedge clk);
    timerA = 1'b0;
    chk("R9 disabled timer no load", code(0), 12'h111);
    chk("R9 disabled no flag", irq[0], 0);

    done = 1'b1;
    finish();
  end

endmodule